// File: doc/BRIEF.md
# CAN Controller Interrupt Status Logic

This block holds the interrupt status word of a CAN-style bus controller. The protocol core feeds it a mix of levels and one-cycle pulses. The levels are:

- receive FIFO non-empty
- transmit buffer free
- error flag and bus-off flag
- overrun flag
- bus idle
- the transmit and receive error counters

The pulses are arbitration lost and bus error. Each source has its own trigger rule: a plain level, a rising edge, any change, or the error-passive threshold being crossed in either direction. Each source is also gated by its own bit of an enable word. Triggered events are latched into status bits, and the block drives a single interrupt line that is the OR of the whole status word.

Software reads the status word through `irq_status` and pulses `status_rd` to acknowledge the read. The read clears every latched bit on the next clock edge. An event that arrives in the same cycle as the read wins, so it is never lost. The receive bit is not latched: it simply follows the receive level gated by its enable.

Bit positions in the status word and in the enable word are the same:

| Bit | Source |
|-----|--------|
| 0 | receive |
| 1 | transmit |
| 2 | error warning |
| 3 | overrun |
| 4 | reserved |
| 5 | error passive |
| 6 | arbitration lost |
| 7 | bus error |
| 8 | idle |

Top module: `can_irq_status`

## Requirements
- R1: After an active-low reset, with all inputs low, `irq_status` is 0 and `irq` is 0.
- R2: Bit 0 equals `rx_fifo_nonempty` AND enable bit 0 in the same cycle. It is never latched.
- R3: Bit 1 is set on a 0-to-1 transition of `tx_buf_free` when enable bit 1 is set. A falling edge or a held high level does not set it.
- R4: Bit 2 is set on any change, rising or falling, of `err_flag` or `bus_off_flag` when enable bit 2 is set.
- R5: Bit 3 is set on a 0-to-1 transition of `overrun_flag` when enable bit 3 is set. A falling edge does not set it.
- R6: Bit 4 always reads 0, whatever enable bit 4 or any input does.
- R7: Bit 5 is set, when enable bit 5 is set, whenever the error-passive condition changes. The condition holds when either error counter is above 127: a count of 127 is active and 128 is passive. Switching which counter holds the condition is not a change.
- R8: Bit 6 is set by a pulse on `arb_lost_pulse` and bit 7 by a pulse on `bus_err_pulse`, each when its own enable bit is set.
- R9: Bit 8 is set on a 0-to-1 transition of `bus_idle` when enable bit 8 is set.
- R10: A source whose enable bit is clear sets nothing. Clearing an enable bit does not clear a bit that is already latched.
- R11: A cycle with `status_rd` high clears latched bits 1 to 8 at the next edge, except a bit whose event occurs in that same cycle, which stays set.
- R12: `irq` equals the OR of all bits of `irq_status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fifo_nonempty | input | 1 | Receive FIFO holds at least one frame |
| tx_buf_free | input | 1 | Transmit buffer is free |
| err_flag | input | 1 | Error status flag |
| bus_off_flag | input | 1 | Bus status flag |
| overrun_flag | input | 1 | Data overrun flag |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| arb_lost_pulse | input | 1 | One-cycle pulse: arbitration lost |
| bus_err_pulse | input | 1 | One-cycle pulse: bus error detected |
| bus_idle | input | 1 | Bus is idle |
| irq_enable | input | 9 | Per-source enable, same bit positions as the status word |
| status_rd | input | 1 | Status read strobe; clears latched bits |
| irq_status | output | 9 | Status word |
| irq | output | 1 | Combined interrupt line |

## Verification
Each source is driven through its own trigger rule, and the opposite pattern is driven next to it, so the check separates the rules. Rising-edge sources also get a falling edge and a held level, which must stay silent. The change-detect source gets both edges on both of its flags. The counters are stepped across the 127/128 boundary, and the passive condition is then handed from one counter to the other. Reads are issued both with and without a coincident event, and the enable word is cleared before and after events, which separates gating from clearing.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int IRQ_W = 9;

    // status / enable bit positions (software decodes these)
    localparam int B_RX   = 0;
    localparam int B_TX   = 1;
    localparam int B_EW   = 2;
    localparam int B_OV   = 3;
    localparam int B_RSV  = 4;
    localparam int B_EP   = 5;
    localparam int B_AL   = 6;
    localparam int B_BE   = 7;
    localparam int B_IDLE = 8;

    // level inputs watched by the edge detector
    localparam int LVL_W  = 5;
    localparam int L_TX   = 0;
    localparam int L_ES   = 1;
    localparam int L_BS   = 2;
    localparam int L_OV   = 3;
    localparam int L_IDLE = 4;

    // 1 = any change, 0 = rising edge only
    localparam logic [LVL_W-1:0] LVL_ANY_MASK = 5'b00110;

    // bits held in flops (everything except receive level and reserved)
    localparam logic [IRQ_W-1:0] LATCH_MASK = 9'b1_1110_1110;

    typedef logic [IRQ_W-1:0] irq_vec_t;

endpackage

// File: rtl/can_irq_edge_detect.sv
module can_irq_edge_detect #(
    parameter int               WIDTH    = 5,
    parameter logic [WIDTH-1:0] ANY_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_i,
    output logic [WIDTH-1:0] evt_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (ANY_MASK[i]) begin : g_any
            assign evt_o[i] = sig_i[i] ^ st_q.prev[i];
        end else begin : g_rise
            assign evt_o[i] = sig_i[i] & ~st_q.prev[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_irq_passive_track.sv
module can_irq_passive_track #(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 8,
    parameter int LIMIT   = 127
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    output logic                          flip_o
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    typedef struct packed {
        logic passive;
    } state_t;

    state_t             st_d, st_q;
    logic [NUM_CNT-1:0] over;
    logic               passive_now;

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        assign over[c] = cnt_i[c] > LIMIT_V;
    end

    assign passive_now = |over;

    always_comb begin
        st_d         = st_q;
        st_d.passive = passive_now;
    end

    assign flip_o = passive_now ^ st_q.passive;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_irq_status_reg.sv
module can_irq_status_reg #(
    parameter int           W    = 9,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] level_i,
    input  logic         clr_i,
    output logic [W-1:0] status_o
);

    typedef struct packed {
        logic [W-1:0] lat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // a coinciding set wins over the read clear
        st_d.lat = ((st_q.lat & ~({W{clr_i}} & MASK)) | set_i) & MASK;
    end

    assign status_o = (st_q.lat & MASK) | (level_i & ~MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LIM = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_fifo_nonempty,
    input  logic             tx_buf_free,
    input  logic             err_flag,
    input  logic             bus_off_flag,
    input  logic             overrun_flag,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             arb_lost_pulse,
    input  logic             bus_err_pulse,
    input  logic             bus_idle,
    input  logic [IRQ_W-1:0] irq_enable,
    input  logic             status_rd,
    output logic [IRQ_W-1:0] irq_status,
    output logic             irq
);

    localparam int NUM_CNT = 2;

    logic [LVL_W-1:0]              lvl;
    logic [LVL_W-1:0]              lvl_evt;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnts;
    logic                          ep_flip;
    irq_vec_t                      raw_evt;
    irq_vec_t                      set_vec;
    irq_vec_t                      level_vec;

    always_comb begin
        lvl         = '0;
        lvl[L_TX]   = tx_buf_free;
        lvl[L_ES]   = err_flag;
        lvl[L_BS]   = bus_off_flag;
        lvl[L_OV]   = overrun_flag;
        lvl[L_IDLE] = bus_idle;
    end

    assign cnts[0] = tx_err_cnt;
    assign cnts[1] = rx_err_cnt;

    can_irq_edge_detect #(
        .WIDTH    (LVL_W),
        .ANY_MASK (LVL_ANY_MASK)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (lvl),
        .evt_o (lvl_evt)
    );

    can_irq_passive_track #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .LIMIT   (PASSIVE_LIM)
    ) u_passive (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnts),
        .flip_o (ep_flip)
    );

    always_comb begin
        raw_evt         = '0;
        raw_evt[B_TX]   = lvl_evt[L_TX];
        raw_evt[B_EW]   = lvl_evt[L_ES] | lvl_evt[L_BS];
        raw_evt[B_OV]   = lvl_evt[L_OV];
        raw_evt[B_EP]   = ep_flip;
        raw_evt[B_AL]   = arb_lost_pulse;
        raw_evt[B_BE]   = bus_err_pulse;
        raw_evt[B_IDLE] = lvl_evt[L_IDLE];
        set_vec         = raw_evt & irq_enable;

        level_vec       = '0;
        level_vec[B_RX] = rx_fifo_nonempty & irq_enable[B_RX];
    end

    can_irq_status_reg #(
        .W    (IRQ_W),
        .MASK (LATCH_MASK)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .level_i  (level_vec),
        .clr_i    (status_rd),
        .status_o (irq_status)
    );

    assign irq = |irq_status;

endmodule

// File: rtl/can_irq_checker.sv
module can_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_buf_free,
    input logic       overrun_flag,
    input logic       arb_lost_pulse,
    input logic       bus_err_pulse,
    input logic [8:0] irq_enable,
    input logic       status_rd,
    input logic [8:0] irq_status,
    input logic       irq
);

    AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|irq_status)); // R12

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_status[4]); // R6

    AST_TX_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_buf_free) && irq_enable[1]) |=> irq_status[1]); // R3

    AST_OVR_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(overrun_flag) && irq_enable[3]) |=> irq_status[3]); // R5

    AST_PULSES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_pulse && irq_enable[7]) |=> irq_status[7]); // R8

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[1] && !status_rd) |=> irq_status[1]); // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !arb_lost_pulse) |=> !irq_status[6]); // R11

endmodule

bind can_irq_status can_irq_checker chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_buf_free    (tx_buf_free),
    .overrun_flag   (overrun_flag),
    .arb_lost_pulse (arb_lost_pulse),
    .bus_err_pulse  (bus_err_pulse),
    .irq_enable     (irq_enable),
    .status_rd      (status_rd),
    .irq_status     (irq_status),
    .irq            (irq)
);

// File: tb/can_irq_status_tb_top.sv
`timescale 1ns/1ps
module can_irq_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_fifo_nonempty = 0, tx_buf_free = 0, err_flag = 0, bus_off_flag = 0;
    logic       overrun_flag = 0, arb_lost_pulse = 0, bus_err_pulse = 0, bus_idle = 0;
    logic [7:0] tx_err_cnt = 0, rx_err_cnt = 0;
    logic [8:0] irq_enable = 0;
    logic       status_rd = 0;
    logic [8:0] irq_status;
    logic       irq;

    // staged values, applied by the driver one cycle at a time
    logic       n_rx = 0, n_tx = 0, n_es = 0, n_bs = 0, n_ov = 0, n_al = 0, n_be = 0, n_idle = 0, n_rd = 0;
    logic [7:0] n_tec = 0, n_rec = 0;
    logic [8:0] n_en = 0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        logic [8:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    item_t it;

    always #5 clk = ~clk;

    can_irq_status dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_fifo_nonempty (rx_fifo_nonempty),
        .tx_buf_free      (tx_buf_free),
        .err_flag         (err_flag),
        .bus_off_flag     (bus_off_flag),
        .overrun_flag     (overrun_flag),
        .tx_err_cnt       (tx_err_cnt),
        .rx_err_cnt       (rx_err_cnt),
        .arb_lost_pulse   (arb_lost_pulse),
        .bus_err_pulse    (bus_err_pulse),
        .bus_idle         (bus_idle),
        .irq_enable       (irq_enable),
        .status_rd        (status_rd),
        .irq_status       (irq_status),
        .irq              (irq)
    );

    // driver: apply staged inputs for one cycle, push what must be seen after the edge
    task automatic cyc(input logic [8:0] exp, input string tag);
        item_t e;
        @(negedge clk);
        #1;
        rx_fifo_nonempty = n_rx; tx_buf_free = n_tx; err_flag = n_es; bus_off_flag = n_bs;
        overrun_flag = n_ov; arb_lost_pulse = n_al; bus_err_pulse = n_be; bus_idle = n_idle;
        tx_err_cnt = n_tec; rx_err_cnt = n_rec; irq_enable = n_en; status_rd = n_rd;
        n_al = 0; n_be = 0; n_rd = 0;
        @(posedge clk);
        #1;
        e.exp = exp;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare at the falling edge after each pushed cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            compared++;
            if (irq_status !== it.exp) begin
                mismatched++;
                $display("FAIL %s: irq_status=%h expected=%h", it.tag, irq_status, it.exp);
            end
            compared++;
            if (irq !== (|it.exp)) begin
                mismatched++;
                $display("FAIL R12 (%s): irq=%b expected=%b", it.tag, irq, |it.exp);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compared++;
        if (irq_status !== 9'h000 || irq !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: in reset irq_status=%h irq=%b expected=000/0", irq_status, irq);
        end
        rst_n = 1'b1;
        cyc(9'h000, "R1");

        n_en = 9'h1FF;
        n_rx = 1;  cyc(9'h001, "R2");
        n_rx = 0;  cyc(9'h000, "R2 not latched");
        n_tx = 1;  cyc(9'h002, "R3");
        n_rd = 1;  cyc(9'h000, "R11 clear, R3 held high");
        n_tx = 0;  cyc(9'h000, "R3 falling");

        n_es = 1;  cyc(9'h004, "R4 err rise");
        n_rd = 1;  cyc(9'h000, "R11");
        n_bs = 1;  cyc(9'h004, "R4 bus rise");
        n_rd = 1;  cyc(9'h000, "R11");
        n_bs = 0;  cyc(9'h004, "R4 bus fall");
        n_rd = 1; n_es = 0; cyc(9'h004, "R11 coincident event kept");
        n_rd = 1;  cyc(9'h000, "R11");

        n_ov = 1;  cyc(9'h008, "R5");
        n_ov = 0; n_rd = 1; cyc(9'h000, "R5 falling");

        n_tec = 8'd127; cyc(9'h000, "R7 at 127");
        n_tec = 8'd128; cyc(9'h020, "R7 enter");
        n_rd = 1;  cyc(9'h000, "R11");
        n_rec = 8'd200; cyc(9'h000, "R7 still passive");
        n_tec = 8'd0;   cyc(9'h000, "R7 handover");
        n_rec = 8'd127; cyc(9'h020, "R7 leave");
        n_rd = 1;  cyc(9'h000, "R11");

        n_al = 1;  cyc(9'h040, "R8 arb");
        n_be = 1;  cyc(9'h0C0, "R8 bus err");
        n_rd = 1;  cyc(9'h000, "R11");

        n_idle = 1; cyc(9'h100, "R9");
        n_rd = 1;   cyc(9'h000, "R11");
        n_idle = 0; cyc(9'h000, "R9 falling");

        n_en = 9'h000; n_tx = 1; n_ov = 1; n_rx = 1; cyc(9'h000, "R10 gated");
        n_en = 9'h1FF; cyc(9'h001, "R10 no late set");
        n_tx = 0; n_ov = 0; n_rx = 0; cyc(9'h000, "R10");
        n_tx = 1;  cyc(9'h002, "R3");
        n_tx = 0; n_en = 9'h000; cyc(9'h002, "R10 latched stays");
        n_rd = 1;  cyc(9'h000, "R11");

        n_en = 9'h010; n_es = 1; n_ov = 1; n_tx = 1; n_rx = 1; n_al = 1; cyc(9'h000, "R6");
        n_es = 0; n_ov = 0; n_tx = 0; n_rx = 0; cyc(9'h000, "R6");

        @(negedge clk);
        @(negedge clk);
        summary();
    end

endmodule